// File: doc/BRIEF.md
# Transmit Line Encoder with Violation Insertion

This block is the digital transmit front end of one T1/E1 line channel. On each falling edge of the transmit clock it samples two data inputs and turns them into a line symbol: a positive pulse, a negative pulse or a space. The symbol drives two pulse-enable outputs for the analog driver that follows. A third output enables that driver once the block is out of reset.

There are two rail modes. In dual rail mode the two inputs are positive and negative NRZ rails. Each pair of sampled bits maps directly to one symbol. In single rail mode the first input carries NRZ data, encoded with alternate mark inversion. The second input then serves as a test request: its rising edge forces the next mark to repeat the polarity of the previous pulse, which creates a bipolar violation. When the channel is configured for dual rail, a long run of high samples on the negative rail makes it fall back to single rail. It stays in single rail until reset.

Top module: `txe_line_encoder`

## Requirements
- R1: While `rst_n` is low, `pulse_pos`, `pulse_neg` and `drive_en` are low. `drive_en` goes high at the first falling edge of `tx_clk` after reset is released and stays high.
- R2: The inputs are sampled only on the falling edge of `tx_clk`. The symbol for a sample appears on the outputs at that same falling edge and holds until the next one.
- R3: In dual rail mode the sampled pair (`tx_data_p`,`tx_data_n`) maps as follows: 1/0 gives a positive pulse, 0/1 gives a negative pulse, and 0/0 and 1/1 give a space. A pulse sent in dual rail also becomes the polarity reference for later single rail marks.
- R4: In single rail mode a sampled 0 on `tx_data_p` gives a space. A sampled 1 gives a pulse whose polarity is opposite to the previous pulse.
- R5: After reset the polarity reference is "last pulse negative", so the first mark is positive.
- R6: In single rail mode with `ami_code_sel`=1, a sample in which `tx_data_n` is 1 after a 0 records a violation request. The next mark, including a mark in that same sample, takes the same polarity as the previous pulse.
- R7: Only one violation is applied, however many rising edges occur before the mark. The mark after a violation alternates from the polarity actually sent.
- R8: With `ami_code_sel`=0, rising edges on `tx_data_n` are not recorded. Setting `ami_code_sel` back to 1 later does not cause a violation from an earlier edge.
- R9: When `dual_rail_cfg`=1 and `tx_data_n` is sampled high HOLD_LIMIT+1 (17) times in a row, that sample is still encoded as dual rail. Every later sample uses single rail until reset.
- R10: A low sample of `tx_data_n` in dual rail mode restarts the count, so two runs of 16 high samples separated by one low sample do not cause fallback.
- R11: `pulse_pos` and `pulse_neg` are never high together.
- R12: `dual_rail_cfg`=0 selects single rail mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; all sampling happens on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_rail_cfg | input | 1 | 1 requests dual rail mode, 0 selects single rail mode |
| ami_code_sel | input | 1 | 1 when plain AMI coding is selected; violation requests are honoured only then |
| tx_data_p | input | 1 | NRZ data in single rail mode, positive rail in dual rail mode |
| tx_data_n | input | 1 | Violation request in single rail mode, negative rail in dual rail mode |
| pulse_pos | output | 1 | Positive pulse enable to the line driver |
| pulse_neg | output | 1 | Negative pulse enable to the line driver |
| drive_en | output | 1 | Line driver output enable |

## Verification
Each symbol is due at the falling edge that samples its inputs and holds for one full clock period. The bench therefore changes the inputs just after a rising edge and compares the outputs at the following rising edge, never in the half period in which they change. A behavioural model updates on the same falling edges and is compared with the outputs on every clock. The fallback checks count samples exactly: the 17th consecutive high sample must still be encoded as dual rail, and the 18th must already be encoded as single rail. Violation checks look at the polarity of the mark that follows the request edge and of the mark after that.

// File: rtl/txe_pkg.sv
package txe_pkg;
    localparam int HOLD_LIMIT_DEF = 16;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_POS   = 2'b01,
        SYM_NEG   = 2'b10
    } line_sym_e;
endpackage

// File: rtl/txe_rail_monitor.sv
module txe_rail_monitor #(
    parameter int HOLD_LIMIT = txe_pkg::HOLD_LIMIT_DEF
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic dual_cfg,
    input  logic neg_in,
    output logic dual_act
);
    localparam int CW = $clog2(HOLD_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD_LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fell_back;
    } mon_t;

    mon_t st_d, st_q;

    assign dual_act = dual_cfg & ~st_q.fell_back;

    always_comb begin
        st_d = st_q;
        if (dual_act && neg_in) begin
            if (st_q.cnt == LIM) begin
                st_d.fell_back = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txe_viol_req.sv
module txe_viol_req (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic arm,
    input  logic mark,
    output logic viol_now
);
    typedef struct packed {
        logic prev;
        logic pend;
    } req_t;

    req_t st_d, st_q;
    logic rise;

    assign rise     = req_in & ~st_q.prev;
    assign viol_now = arm & (st_q.pend | rise);

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_in;
        st_d.pend = viol_now & ~mark;
    end

    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txe_symbol_map.sv
module txe_symbol_map
    import txe_pkg::*;
(
    input  logic tx_clk,
    input  logic rst_n,
    input  logic dual_act,
    input  logic pos_in,
    input  logic neg_in,
    input  logic viol_now,
    output logic pulse_pos,
    output logic pulse_neg
);
    typedef struct packed {
        logic      last_neg;
        line_sym_e sym;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sym = SYM_SPACE;
        if (dual_act) begin
            case ({pos_in, neg_in})
                2'b10:   st_d.sym = SYM_POS;
                2'b01:   st_d.sym = SYM_NEG;
                default: st_d.sym = SYM_SPACE;
            endcase
        end else if (pos_in) begin
            if (viol_now) begin
                st_d.sym = st_q.last_neg ? SYM_NEG : SYM_POS;
            end else begin
                st_d.sym = st_q.last_neg ? SYM_POS : SYM_NEG;
            end
        end
        if (st_d.sym == SYM_POS) begin
            st_d.last_neg = 1'b0;
        end else if (st_d.sym == SYM_NEG) begin
            st_d.last_neg = 1'b1;
        end
    end

    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last_neg <= 1'b1;
            st_q.sym      <= SYM_SPACE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_pos = (st_q.sym == SYM_POS);
    assign pulse_neg = (st_q.sym == SYM_NEG);
endmodule

// File: rtl/txe_line_encoder.sv
module txe_line_encoder #(
    parameter int HOLD_LIMIT = txe_pkg::HOLD_LIMIT_DEF
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic dual_rail_cfg,
    input  logic ami_code_sel,
    input  logic tx_data_p,
    input  logic tx_data_n,
    output logic pulse_pos,
    output logic pulse_neg,
    output logic drive_en
);
    logic dual_act;
    logic viol_now;
    logic en_d, en_q;

    txe_rail_monitor #(.HOLD_LIMIT(HOLD_LIMIT)) u_mon (
        .tx_clk   (tx_clk),
        .rst_n    (rst_n),
        .dual_cfg (dual_rail_cfg),
        .neg_in   (tx_data_n),
        .dual_act (dual_act)
    );

    txe_viol_req u_viol (
        .tx_clk   (tx_clk),
        .rst_n    (rst_n),
        .req_in   (tx_data_n),
        .arm      (~dual_act & ami_code_sel),
        .mark     (~dual_act & tx_data_p),
        .viol_now (viol_now)
    );

    txe_symbol_map u_map (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .dual_act  (dual_act),
        .pos_in    (tx_data_p),
        .neg_in    (tx_data_n),
        .viol_now  (viol_now),
        .pulse_pos (pulse_pos),
        .pulse_neg (pulse_neg)
    );

    always_comb begin
        en_d = 1'b1;
    end

    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign drive_en = en_q;
endmodule

// File: rtl/txe_line_encoder_chk.sv
module txe_line_encoder_chk (
    input logic tx_clk,
    input logic rst_n,
    input logic dual_act,
    input logic tx_data_p,
    input logic tx_data_n,
    input logic pulse_pos,
    input logic pulse_neg,
    input logic drive_en
);
    AST_PULSE_EXCL: assert property (@(negedge tx_clk) disable iff (!rst_n)
        !(pulse_pos && pulse_neg)); // R11

    AST_DUAL_POS: assert property (@(negedge tx_clk) disable iff (!rst_n)
        (dual_act && tx_data_p && !tx_data_n) |=> (pulse_pos && !pulse_neg)); // R3

    AST_DUAL_NEG: assert property (@(negedge tx_clk) disable iff (!rst_n)
        (dual_act && !tx_data_p && tx_data_n) |=> (pulse_neg && !pulse_pos)); // R3

    AST_SINGLE_ZERO: assert property (@(negedge tx_clk) disable iff (!rst_n)
        (!dual_act && !tx_data_p) |=> (!pulse_pos && !pulse_neg)); // R4

    AST_SINGLE_MARK: assert property (@(negedge tx_clk) disable iff (!rst_n)
        (!dual_act && tx_data_p) |=> (pulse_pos != pulse_neg)); // R4

    AST_DRIVE_HOLD: assert property (@(negedge tx_clk) disable iff (!rst_n)
        drive_en |=> drive_en); // R1
endmodule

bind txe_line_encoder txe_line_encoder_chk u_chk (
    .tx_clk    (tx_clk),
    .rst_n     (rst_n),
    .dual_act  (dual_act),
    .tx_data_p (tx_data_p),
    .tx_data_n (tx_data_n),
    .pulse_pos (pulse_pos),
    .pulse_neg (pulse_neg),
    .drive_en  (drive_en)
);

// File: tb/tb_txe_line_encoder.sv
`timescale 1ns/1ps
module tb_txe_line_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dual_rail_cfg = 1'b1;
    logic ami_code_sel = 1'b1;
    logic tx_data_p = 1'b0;
    logic tx_data_n = 1'b0;
    logic pulse_pos, pulse_neg, drive_en;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    txe_line_encoder dut (
        .tx_clk(clk), .rst_n(rst_n), .dual_rail_cfg(dual_rail_cfg),
        .ami_code_sel(ami_code_sel), .tx_data_p(tx_data_p), .tx_data_n(tx_data_n),
        .pulse_pos(pulse_pos), .pulse_neg(pulse_neg), .drive_en(drive_en)
    );

    // behavioural reference model
    int m_cnt;
    bit m_fb, m_prev, m_pend, m_lastneg, e_p, e_n, e_en;
    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_fb = 0; m_prev = 0; m_pend = 0; m_lastneg = 1;
            e_p = 0; e_n = 0; e_en = 0;
        end else begin
            bit dual, eff;
            dual = dual_rail_cfg && !m_fb;
            e_p = 0; e_n = 0;
            if (dual) begin
                e_p = tx_data_p && !tx_data_n;
                e_n = !tx_data_p && tx_data_n;
                if (tx_data_n) begin
                    if (m_cnt >= 16) m_fb = 1; else m_cnt++;
                end else m_cnt = 0;
                m_pend = 0;
            end else begin
                m_cnt = 0;
                eff = ami_code_sel && (m_pend || (tx_data_n && !m_prev));
                if (tx_data_p) begin
                    if (eff) begin e_p = !m_lastneg; e_n = m_lastneg; end
                    else     begin e_p = m_lastneg;  e_n = !m_lastneg; end
                end
                m_pend = eff && !tx_data_p;
            end
            if (e_p) m_lastneg = 0;
            if (e_n) m_lastneg = 1;
            m_prev = tx_data_n;
            e_en = 1;
        end
    end

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {en,pos,neg} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against model on every clock
    always @(posedge clk) begin
        if (!done) begin
            cycles++;
            chk(cur_req, {drive_en, pulse_pos, pulse_neg}, {e_en, e_p, e_n});
        end
    end

    initial begin
        wait (cycles > 5000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic cyc(input logic p, input logic n);
        tx_data_p = p; tx_data_n = n;
        @(posedge clk); #1;
    endtask

    task automatic reset_pulse();
        tx_data_p = 0; tx_data_n = 0;
        rst_n = 0; @(posedge clk); #1;
        rst_n = 1; @(posedge clk); #1;
    endtask

    function automatic logic [2:0] outs();
        return {drive_en, pulse_pos, pulse_neg};
    endfunction

    initial begin
        repeat (3) @(posedge clk); #1;
        chk("R1", outs(), 3'b000);
        rst_n = 1; @(posedge clk); #1;
        chk("R1", outs(), 3'b100);

        cur_req = "R3";
        cyc(1, 0); chk("R3", outs(), 3'b110);
        cyc(0, 1); chk("R3", outs(), 3'b101);
        cyc(1, 1); chk("R3", outs(), 3'b100);
        cyc(0, 0); chk("R3", outs(), 3'b100);
        cur_req = "R2";
        tx_data_p = 1; #2;
        chk("R2", outs(), 3'b100);
        @(posedge clk); #1;
        chk("R2", outs(), 3'b110);

        cur_req = "R5";
        dual_rail_cfg = 0;
        reset_pulse();
        cyc(1, 0); chk("R5", outs(), 3'b110);
        cur_req = "R4";
        cyc(1, 0); chk("R4", outs(), 3'b101);
        cyc(0, 0); chk("R4", outs(), 3'b100);
        cyc(1, 0); chk("R4", outs(), 3'b110);

        cur_req = "R6";
        cyc(0, 1); chk("R6", outs(), 3'b100);
        cyc(1, 1); chk("R6", outs(), 3'b110);
        cur_req = "R7";
        cyc(1, 1); chk("R7", outs(), 3'b101);
        cyc(0, 0);
        cyc(0, 1);
        cyc(0, 0);
        cyc(0, 1);
        cyc(1, 0); chk("R7", outs(), 3'b101);
        cyc(1, 0); chk("R7", outs(), 3'b110);
        cur_req = "R6";
        cyc(0, 0);
        cyc(1, 1); chk("R6", outs(), 3'b110);

        cur_req = "R8";
        ami_code_sel = 0;
        cyc(0, 0);
        cyc(0, 1);
        cyc(1, 1); chk("R8", outs(), 3'b101);
        ami_code_sel = 1;
        cyc(1, 1); chk("R8", outs(), 3'b110);
        cur_req = "R12";
        cyc(0, 0);
        cyc(1, 0); chk("R12", outs(), 3'b101);

        cur_req = "R10";
        dual_rail_cfg = 1;
        reset_pulse();
        for (int i = 0; i < 16; i++) cyc(0, 1);
        cyc(0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 1);
        cyc(0, 0);
        cyc(1, 1); chk("R10", outs(), 3'b100);
        cur_req = "R9";
        for (int i = 0; i < 16; i++) cyc(0, 1);
        chk("R9", outs(), 3'b101);
        cyc(1, 1); chk("R9", outs(), 3'b110);
        cyc(1, 1); chk("R9", outs(), 3'b101);
        cyc(0, 1); chk("R9", outs(), 3'b100);
        cyc(0, 0);
        cyc(1, 0); chk("R9", outs(), 3'b110);
        cur_req = "R11";
        cyc(1, 0); chk("R11", {1'b1, pulse_pos & pulse_neg, 1'b0}, 3'b100);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule